// File: doc/BRIEF.md
# SDLC Loop Insertion Controller

This block decides when a station joins or leaves an SDLC loop and what is driven on the outgoing serial line meanwhile. It watches the received bit stream, strobe by strobe, for an end-of-poll mark. An end-of-poll mark is a zero followed by a parameterised run of ones, seven by default. While the block is waiting to join, it repeats the received stream one bit late. It joins the loop at an end-of-poll mark seen while the go-active-on-poll control is high. After it has joined, it leaves only at the next end-of-poll mark after loop mode is dropped.

When the station is on the loop and go-active-on-poll is high, an end-of-poll mark is not repeated as received. Its last bit goes out as a zero, so the mark becomes a flag. From the next receive strobe the local transmitter owns the line and can send its own frames. When go-active-on-poll is low, an on-loop station is a one-bit-delay repeater. When the station is off the loop, the local transmitter drives the line directly.

Loop mode has no effect in asynchronous operation. A synchronous channel reset or the hardware reset returns the block to the off-loop state.

Top module: `loop_insert_ctrl`

## Requirements
- R1: After hardware reset, on_loop_o is 0, local_en_o is 1 and txd_o equals local_tx_i.
- R2: On the first receive strobe with loop mode set (and asynchronous mode clear), the block starts hunting. While it hunts, local_en_o is 0 and txd_o equals the bit received at the most recent strobe.
- R3: The block goes on-loop (on_loop_o = 1) at the strobe that completes an end-of-poll mark, but only if go_active_i is 1 at that strobe. An end-of-poll mark is a 0 followed by EOP_ONES ones, where the 0 is the oldest bit. An end-of-poll mark completed with go_active_i at 0 leaves the block off-loop.
- R4: on_loop_o changes only on a cycle with rx_en_i high, or after chan_rst_i.
- R5: If loop mode is cleared while on-loop, on_loop_o stays 1 through non-end-of-poll bits and falls at the strobe that completes the next end-of-poll mark. From then on, local_en_o is 1.
- R6: When chan_rst_i is high at a clock edge, the block returns to the off-loop state, with on_loop_o 0 and local_en_o 1.
- R7: While async_mode_i is 1, loop_mode_i is ignored: the block does not leave the off-loop state, and txd_o follows local_tx_i.
- R8: While on-loop with go_active_i at 1, an end-of-poll mark makes the block replace the final bit of the mark with 0. The replaced bit is shown on txd_o with local_en_o 0. From the next strobe, local_en_o is 1 and txd_o equals local_tx_i.
- R9: While on-loop with go_active_i at 0, local_en_o is 0 and txd_o repeats each received bit one strobe late.
- R10: A run of ones with no leading 0 is not an end-of-poll mark. Eight ones in a row, received while hunting with go_active_i at 1, leave the block off-loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| chan_rst_i | input | 1 | Channel reset, synchronous, active high |
| async_mode_i | input | 1 | Channel is in asynchronous operation |
| loop_mode_i | input | 1 | Loop mode request |
| go_active_i | input | 1 | Go-active-on-poll control |
| rx_bit_i | input | 1 | Received serial bit |
| rx_en_i | input | 1 | Receive bit strobe, one clock per bit |
| local_tx_i | input | 1 | Bit from the local transmitter |
| txd_o | output | 1 | Outgoing serial bit |
| on_loop_o | output | 1 | Station is inserted in the loop |
| local_en_o | output | 1 | Local transmitter owns the outgoing line |

## Verification
A wrong loop state shows on the ports no later than the next receive strobe. When the block is wrongly hunting, local_en_o drops and txd_o shows the delayed receive bit instead of the local one. When the block is wrongly on-loop, on_loop_o is high and end-of-poll marks are turned into flags. A corrupted end-of-poll history shows up as a missed or false join, or a missed or false leave, at the strobe that completes the mark. A wrong repeat register makes txd_o differ from the bit received one strobe earlier.

// File: rtl/loop_pkg.sv
package loop_pkg;
   typedef enum logic [1:0] {
      LS_OFF  = 2'd0,
      LS_HUNT = 2'd1,
      LS_ON   = 2'd2
   } loop_state_e;
endpackage

// File: rtl/loop_eop_detect.sv
module loop_eop_detect #(
   parameter int EOP_ONES = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic en_i,
   input  logic bit_i,
   output logic eop_o
);
   localparam int WIN = EOP_ONES + 1;

   logic [EOP_ONES-1:0] hist_q;
   logic [WIN-1:0]      window;
   logic [WIN-1:0]      pattern;

   // pattern: oldest bit zero, the rest ones
   for (genvar i = 0; i < WIN; i++) begin : g_pat
      if (i == WIN - 1) begin : g_zero
         assign pattern[i] = 1'b0;
      end else begin : g_one
         assign pattern[i] = 1'b1;
      end
   end

   assign window = {hist_q, bit_i};
   assign eop_o  = en_i && (window == pattern);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '1;
      end else if (clr_i) begin
         hist_q <= '1;
      end else if (en_i) begin
         hist_q <= window[EOP_ONES-1:0];
      end
   end
endmodule

// File: rtl/loop_seq_fsm.sv
module loop_seq_fsm
   import loop_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr_i,
   input  logic        en_i,
   input  logic        eop_i,
   input  logic        loop_i,
   input  logic        goap_i,
   output loop_state_e state_o,
   output logic        convert_o,
   output logic        sending_o
);
   loop_state_e state_q, state_d;
   logic        conv_q;
   logic        send_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         LS_OFF:  if (loop_i) state_d = LS_HUNT;
         LS_HUNT: begin
            if (!loop_i)             state_d = LS_OFF;
            else if (eop_i && goap_i) state_d = LS_ON;
         end
         LS_ON:   if (!loop_i && eop_i) state_d = LS_OFF;
         default: state_d = LS_OFF;
      endcase
   end

   // mark to flag rewrite only when staying on the loop
   assign convert_o = en_i && (state_q == LS_ON) && (state_d == LS_ON)
                      && eop_i && goap_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= LS_OFF;
         conv_q  <= 1'b0;
         send_q  <= 1'b0;
      end else if (clr_i) begin
         state_q <= LS_OFF;
         conv_q  <= 1'b0;
         send_q  <= 1'b0;
      end else if (en_i) begin
         state_q <= state_d;
         conv_q  <= convert_o;
         send_q  <= (state_d == LS_ON) && goap_i && (send_q || conv_q);
      end
   end

   assign state_o   = state_q;
   assign sending_o = send_q;
endmodule

// File: rtl/loop_tx_path.sv
module loop_tx_path
   import loop_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr_i,
   input  logic        en_i,
   input  logic        bit_i,
   input  logic        convert_i,
   input  loop_state_e state_i,
   input  logic        sending_i,
   input  logic        local_i,
   output logic        txd_o,
   output logic        local_en_o
);
   logic rep_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rep_q <= 1'b1;
      end else if (clr_i) begin
         rep_q <= 1'b1;
      end else if (en_i) begin
         rep_q <= convert_i ? 1'b0 : bit_i;
      end
   end

   always_comb begin
      unique case (state_i)
         LS_HUNT: begin
            txd_o      = rep_q;
            local_en_o = 1'b0;
         end
         LS_ON: begin
            txd_o      = sending_i ? local_i : rep_q;
            local_en_o = sending_i;
         end
         default: begin
            txd_o      = local_i;
            local_en_o = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/loop_insert_ctrl.sv
module loop_insert_ctrl
   import loop_pkg::*;
#(
   parameter int EOP_ONES = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic chan_rst_i,
   input  logic async_mode_i,
   input  logic loop_mode_i,
   input  logic go_active_i,
   input  logic rx_bit_i,
   input  logic rx_en_i,
   input  logic local_tx_i,
   output logic txd_o,
   output logic on_loop_o,
   output logic local_en_o
);
   if (EOP_ONES < 2 || EOP_ONES > 30) begin : g_bad_ones
      $error("loop_insert_ctrl: EOP_ONES out of range");
   end

   logic        loop_eff;
   logic        eop_hit;
   logic        convert;
   logic        sending;
   loop_state_e state;

   assign loop_eff = loop_mode_i && !async_mode_i;

   loop_eop_detect #(.EOP_ONES(EOP_ONES)) u_detect (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (chan_rst_i),
      .en_i  (rx_en_i),
      .bit_i (rx_bit_i),
      .eop_o (eop_hit)
   );

   loop_seq_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (chan_rst_i),
      .en_i      (rx_en_i),
      .eop_i     (eop_hit),
      .loop_i    (loop_eff),
      .goap_i    (go_active_i),
      .state_o   (state),
      .convert_o (convert),
      .sending_o (sending)
   );

   loop_tx_path u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (chan_rst_i),
      .en_i       (rx_en_i),
      .bit_i      (rx_bit_i),
      .convert_i  (convert),
      .state_i    (state),
      .sending_i  (sending),
      .local_i    (local_tx_i),
      .txd_o      (txd_o),
      .local_en_o (local_en_o)
   );

   assign on_loop_o = (state == LS_ON);
endmodule

// File: rtl/loop_insert_ctrl_checker.sv
module loop_insert_ctrl_checker (
   input logic clk,
   input logic rst_n,
   input logic chan_rst_i,
   input logic async_mode_i,
   input logic loop_mode_i,
   input logic go_active_i,
   input logic rx_bit_i,
   input logic rx_en_i,
   input logic local_tx_i,
   input logic txd_o,
   input logic on_loop_o,
   input logic local_en_o
);
   logic last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          last_q <= 1'b1;
      else if (chan_rst_i) last_q <= 1'b1;
      else if (rx_en_i)    last_q <= rx_bit_i;
   end

   assert_hunt_repeat_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!on_loop_o && !local_en_o) |-> (txd_o == last_q));

   assert_join_cond_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(on_loop_o) |-> $past(rx_en_i && loop_mode_i && !async_mode_i && go_active_i));

   assert_strobe_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_en_i && !chan_rst_i) |=> $stable(on_loop_o));

   assert_leave_cond_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(on_loop_o) && !$past(chan_rst_i)) |->
         $past(rx_en_i && !(loop_mode_i && !async_mode_i)));

   assert_chan_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
      chan_rst_i |=> (!on_loop_o && local_en_o));

   assert_async_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (async_mode_i && !on_loop_o) |=> !on_loop_o);

   assert_local_owns_R8: assert property (@(posedge clk) disable iff (!rst_n)
      local_en_o |-> (txd_o == local_tx_i));
endmodule

bind loop_insert_ctrl loop_insert_ctrl_checker u_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .chan_rst_i   (chan_rst_i),
   .async_mode_i (async_mode_i),
   .loop_mode_i  (loop_mode_i),
   .go_active_i  (go_active_i),
   .rx_bit_i     (rx_bit_i),
   .rx_en_i      (rx_en_i),
   .local_tx_i   (local_tx_i),
   .txd_o        (txd_o),
   .on_loop_o    (on_loop_o),
   .local_en_o   (local_en_o)
);

// File: tb/loop_insert_ctrl_bench.sv
module loop_insert_ctrl_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic chan_rst_i = 1'b0;
   logic async_mode_i = 1'b0;
   logic loop_mode_i = 1'b0;
   logic go_active_i = 1'b0;
   logic rx_bit_i = 1'b1;
   logic rx_en_i = 1'b0;
   logic local_tx_i = 1'b0;
   logic txd_o, on_loop_o, local_en_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   loop_insert_ctrl u_loop_insert_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .chan_rst_i   (chan_rst_i),
      .async_mode_i (async_mode_i),
      .loop_mode_i  (loop_mode_i),
      .go_active_i  (go_active_i),
      .rx_bit_i     (rx_bit_i),
      .rx_en_i      (rx_en_i),
      .local_tx_i   (local_tx_i),
      .txd_o        (txd_o),
      .on_loop_o    (on_loop_o),
      .local_en_o   (local_en_o)
   );

   task automatic check(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   // one receive strobe; outputs are settled at the following falling edge
   task automatic send_bit(input logic b);
      @(negedge clk);
      rx_bit_i = b;
      rx_en_i  = 1'b1;
      @(negedge clk);
      rx_en_i  = 1'b0;
      #1;
   endtask

   task automatic send_eop();
      send_bit(1'b0);
      for (int i = 0; i < 7; i++) send_bit(1'b1);
   endtask

   task automatic t_reset();
      local_tx_i = 1'b1;
      #1;
      check("R1", "on_loop after reset", on_loop_o, 1'b0);
      check("R1", "local_en after reset", local_en_o, 1'b1);
      check("R1", "txd follows local=1", txd_o, 1'b1);
      local_tx_i = 1'b0;
      #1;
      check("R1", "txd follows local=0", txd_o, 1'b0);
   endtask

   task automatic t_async();
      async_mode_i = 1'b1;
      loop_mode_i  = 1'b1;
      go_active_i  = 1'b1;
      send_bit(1'b1);
      send_eop();
      check("R7", "on_loop in async", on_loop_o, 1'b0);
      check("R7", "local_en in async", local_en_o, 1'b1);
      local_tx_i = 1'b1;
      #1;
      check("R7", "txd local in async", txd_o, 1'b1);
      local_tx_i = 1'b0;
      async_mode_i = 1'b0;
   endtask

   task automatic t_hunt();
      go_active_i = 1'b0;
      send_bit(1'b0);
      check("R2", "local_en while hunting", local_en_o, 1'b0);
      check("R2", "txd repeats 0", txd_o, 1'b0);
      send_bit(1'b1);
      check("R2", "txd repeats 1", txd_o, 1'b1);
      send_eop();
      check("R3", "no join without go-active", on_loop_o, 1'b0);
      go_active_i = 1'b1;
      for (int i = 0; i < 8; i++) send_bit(1'b1);
      check("R10", "ones without leading zero", on_loop_o, 1'b0);
   endtask

   task automatic t_join();
      go_active_i = 1'b1;
      send_bit(1'b0);
      for (int i = 0; i < 6; i++) send_bit(1'b1);
      check("R3", "not on-loop before final mark bit", on_loop_o, 1'b0);
      repeat (3) @(negedge clk);
      check("R4", "no change without strobe", on_loop_o, 1'b0);
      send_bit(1'b1);
      check("R3", "joined at mark", on_loop_o, 1'b1);
      go_active_i = 1'b0;
      send_bit(1'b0);
      check("R9", "repeat 0 on-loop", txd_o, 1'b0);
      check("R9", "local_en on-loop repeater", local_en_o, 1'b0);
      send_bit(1'b1);
      check("R9", "repeat 1 on-loop", txd_o, 1'b1);
      send_bit(1'b0);
      check("R9", "repeat 0 again", txd_o, 1'b0);
   endtask

   task automatic t_insert();
      go_active_i = 1'b1;
      send_eop();
      check("R8", "final mark bit replaced", txd_o, 1'b0);
      check("R8", "local_en during replaced bit", local_en_o, 1'b0);
      send_bit(1'b1);
      check("R8", "local_en after flag", local_en_o, 1'b1);
      local_tx_i = 1'b1;
      #1;
      check("R8", "txd local=1", txd_o, 1'b1);
      local_tx_i = 1'b0;
      #1;
      check("R8", "txd local=0", txd_o, 1'b0);
   endtask

   task automatic t_leave();
      loop_mode_i = 1'b0;
      send_bit(1'b0);
      send_bit(1'b1);
      check("R5", "still on-loop after clear", on_loop_o, 1'b1);
      send_bit(1'b0);
      for (int i = 0; i < 6; i++) send_bit(1'b1);
      check("R5", "on-loop before final bit", on_loop_o, 1'b1);
      send_bit(1'b1);
      check("R5", "off-loop at mark", on_loop_o, 1'b0);
      check("R5", "local_en off-loop", local_en_o, 1'b1);
   endtask

   task automatic t_chan_reset();
      loop_mode_i = 1'b1;
      go_active_i = 1'b1;
      send_bit(1'b1);
      send_eop();
      check("R6", "on-loop before channel reset", on_loop_o, 1'b1);
      @(negedge clk);
      chan_rst_i = 1'b1;
      @(negedge clk);
      chan_rst_i = 1'b0;
      #1;
      check("R6", "on_loop after channel reset", on_loop_o, 1'b0);
      check("R6", "local_en after channel reset", local_en_o, 1'b1);
      loop_mode_i = 1'b0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_async();
      t_hunt();
      t_join();
      t_insert();
      t_leave();
      t_chan_reset();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule